// File: doc/BRIEF.md
# Synchronous Output Clock Stop Controller

This block derives a group of divided output clocks from a free-running source clock and can park the stoppable members of that group low without producing runt pulses, while a reference divided clock and any exempted outputs keep toggling. Two stop requests are combined, and either one is enough to halt the group: an asynchronous active-low pin, and an active-low bit held in a control register. Each output has its own free-run bit. When that bit is set, the output ignores both stop requests.

The pin is brought into the source clock domain through two flip-flops. The run/stop decision for every output is re-evaluated only at the single source edge where the divided clocks go from low to high. As a result, a halt always starts after a complete high phase, and a restart always begins with a full high phase in phase with the reference clock. A status bit reports whether the stoppable outputs are allowed to run. Software reads this bit back in place of the register stop bit.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While `rst_n` is low, every output clock and the reference clock are low. After reset is released with both stop sources high and the free-run mask zero, every output equals `ref_clk_o` once the first divided period has started.
- R2: `ref_clk_o` never stops. It is high for exactly HALF source cycles and then low for exactly HALF source cycles, so its period is 2*HALF (8 with defaults).
- R3: Once `stop_pin_n` has been held low for two source cycles plus one divided period, each output whose free-run bit is 0 stays at logic low.
- R4: Holding `reg_stop_n` low has the same effect as R3. The effective stop is the OR of the two active-low requests.
- R5: Bit i of `free_run_mask` at 1 makes output i follow `ref_clk_o` whatever the stop inputs are.
- R6: After both stop sources return high, all stoppable outputs resume together within two divided periods. Their first high phase begins on the same edge as a rising edge of `ref_clk_o`.
- R7: No output produces a truncated pulse. Every high phase lasts exactly HALF source cycles. An output rises only together with `ref_clk_o` and falls only together with `ref_clk_o`.
- R8: `status_run_o` is 0 whenever `reg_stop_n` is low or the synchronized pin is low. It reflects a pin change two source cycles after the change, and is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_pin_n | input | 1 | Asynchronous active-low stop request pin |
| reg_stop_n | input | 1 | Active-low stop bit from the control register |
| free_run_mask | input | N_OUT | Per-output free-run enable, 1 = ignore stop |
| ref_clk_o | output | 1 | Always-running divided reference clock |
| clk_o | output | N_OUT | Divided output clocks, stoppable unless exempt |
| status_run_o | output | 1 | Read-back value of the stop bit (0 = stopped) |

## Verification
A corrupted run flag for one output shows up at the ports within one divided period. That output either keeps toggling while the others sit low, or stays low after `ref_clk_o` has started a new high phase. A divider or update-point fault that moves the gating decision off the low-to-high boundary produces a high phase shorter than HALF cycles, or an edge that does not line up with `ref_clk_o`, in the very pulse where the stop or release takes effect. A broken synchronizer stage shifts the `status_run_o` response away from its two-cycle latency.

// File: rtl/clk_stop_pkg.sv
// Package: shared defaults and helpers for the clock stop controller.
// Assumes the divided clock has a 50% duty cycle (HALF high, HALF low).
package clk_stop_pkg;
    localparam int unsigned DEF_HALF  = 4;
    localparam int unsigned DEF_N_OUT = 4;

    // Width of a counter that spans one full divided period.
    function automatic int unsigned cnt_width(input int unsigned half);
        return (half * 2 > 2) ? $clog2(half * 2) : 1;
    endfunction
endpackage

// File: rtl/csc_sync2.sv
// Two-flop synchronizer for one asynchronous level.
// Assumes the input stays at a level longer than two clk cycles to be seen.
// The reset value is 1, which means "not stopped".
module csc_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic meta_q;
    logic hold_q;

    // Shift the asynchronous level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            hold_q <= 1'b1;
        end else begin
            meta_q <= async_i;
            hold_q <= meta_q;
        end
    end

    assign sync_o = hold_q;
endmodule

// File: rtl/csc_divider.sv
// Period counter for the divided clocks.
// Produces the next-cycle level of the divided clock and a flag marking the
// edge where the period restarts (low-to-high), plus the registered reference.
// Assumes HALF >= 1. Reset parks the count at the last cycle so that the first
// edge after reset starts a full high phase.
module csc_divider #(
    parameter int unsigned HALF = clk_stop_pkg::DEF_HALF
) (
    input  logic clk,
    input  logic rst_n,
    output logic hi_next_o,
    output logic wrap_next_o,
    output logic ref_clk_o
);
    localparam int unsigned PERIOD = 2 * HALF;
    localparam int unsigned CW     = clk_stop_pkg::cnt_width(HALF);
    localparam logic [CW-1:0] LAST  = CW'(PERIOD - 1);
    localparam logic [CW-1:0] HALFV = CW'(HALF);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_n;
    logic          ref_q;

    // Next count value: wrap to zero after the last cycle of the period.
    always_comb begin
        cnt_n = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign wrap_next_o = (cnt_q == LAST);
    assign hi_next_o   = (cnt_n < HALFV);

    // Advance the period count and register the reference level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= LAST;
            ref_q <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            ref_q <= hi_next_o;
        end
    end

    assign ref_clk_o = ref_q;
endmodule

// File: rtl/csc_gate_bank.sv
// One run flag and one registered output clock per output.
// Each run flag is updated only at the period restart edge, while all divided
// clocks are low, so a change never cuts a high phase short.
// Assumes hi_next_i / wrap_next_i come from csc_divider in the same domain.
module csc_gate_bank #(
    parameter int unsigned N_OUT = clk_stop_pkg::DEF_N_OUT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [N_OUT-1:0] free_run_i,
    input  logic             hi_next_i,
    input  logic             wrap_next_i,
    output logic [N_OUT-1:0] clk_o
);
    for (genvar g = 0; g < N_OUT; g++) begin : g_lane
        logic run_q;
        logic run_d;
        logic out_q;

        // Pick the run decision for the next period only at the restart edge.
        always_comb begin
            run_d = wrap_next_i ? (free_run_i[g] | go_i) : run_q;
        end

        // Hold the run flag and drive the output level from the common phase.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                run_q <= 1'b1;
                out_q <= 1'b0;
            end else begin
                run_q <= run_d;
                out_q <= hi_next_i & run_d;
            end
        end

        assign clk_o[g] = out_q;
    end
endmodule

// File: rtl/clk_stop_ctrl.sv
// Top level: synchronous stop/start of a group of divided output clocks.
// Merges an asynchronous active-low pin and an active-low register bit into
// one effective stop, exempts outputs whose free-run bit is set, and returns
// the merged run status for register read-back.
// Assumes reg_stop_n and free_run_mask are already synchronous to clk.
module clk_stop_ctrl #(
    parameter int unsigned N_OUT = clk_stop_pkg::DEF_N_OUT,
    parameter int unsigned HALF  = clk_stop_pkg::DEF_HALF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_pin_n,
    input  logic             reg_stop_n,
    input  logic [N_OUT-1:0] free_run_mask,
    output logic             ref_clk_o,
    output logic [N_OUT-1:0] clk_o,
    output logic             status_run_o
);
    logic pin_s;
    logic go;
    logic hi_next;
    logic wrap_next;

    csc_sync2 u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (stop_pin_n),
        .sync_o  (pin_s)
    );

    // Either active-low source being low stops the group.
    always_comb begin
        go = pin_s & reg_stop_n;
    end

    csc_divider #(.HALF(HALF)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .hi_next_o   (hi_next),
        .wrap_next_o (wrap_next),
        .ref_clk_o   (ref_clk_o)
    );

    csc_gate_bank #(.N_OUT(N_OUT)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go),
        .free_run_i  (free_run_mask),
        .hi_next_i   (hi_next),
        .wrap_next_i (wrap_next),
        .clk_o       (clk_o)
    );

    assign status_run_o = go;
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
// Checker for clk_stop_ctrl, attached with bind. It observes ports only.
module clk_stop_ctrl_chk #(
    parameter int unsigned N_OUT = 4,
    parameter int unsigned HALF  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_pin_n,
    input logic             reg_stop_n,
    input logic             ref_clk_o,
    input logic [N_OUT-1:0] clk_o,
    input logic             status_run_o
);
    int unsigned hi_len;
    int unsigned lo_len;
    int unsigned live;

    // Track the reference phase lengths and the cycles since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_len <= 0;
            lo_len <= 0;
            live   <= 0;
        end else begin
            hi_len <= ref_clk_o ? hi_len + 1 : 0;
            lo_len <= ref_clk_o ? 0 : lo_len + 1;
            if (live < 4) live <= live + 1;
        end
    end

    assert_ref_high_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hi_len <= HALF);
    assert_ref_low_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lo_len <= HALF + 1);
    assert_status_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (live >= 3 && !$past(stop_pin_n, 2)) |-> !status_run_o);
    assert_status_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_stop_n |-> !status_run_o);

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        assert_rise_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(clk_o[g]) |-> $rose(ref_clk_o));
        assert_fall_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(clk_o[g]) |-> $fell(ref_clk_o));
        assert_within_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
            clk_o[g] |-> ref_clk_o);
    end
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(.N_OUT(N_OUT), .HALF(HALF)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_pin_n   (stop_pin_n),
    .reg_stop_n   (reg_stop_n),
    .ref_clk_o    (ref_clk_o),
    .clk_o        (clk_o),
    .status_run_o (status_run_o)
);

// File: tb/clk_stop_ctrl_tb_top.sv
// Bench for clk_stop_ctrl: random stop windows plus directed reset/restart cases.
module clk_stop_ctrl_tb_top;
    localparam int N = 4;
    localparam int H = 4;
    localparam int P = 2 * H;
    localparam int SETTLE = 2 * P + 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pin_n = 1'b1;
    logic         reg_n = 1'b1;
    logic [N-1:0] mask = '0;
    logic         ref_clk;
    logic [N-1:0] clk_out;
    logic         status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    clk_stop_ctrl #(.N_OUT(N), .HALF(H)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .stop_pin_n    (pin_n),
        .reg_stop_n    (reg_n),
        .free_run_mask (mask),
        .ref_clk_o     (ref_clk),
        .clk_o         (clk_out),
        .status_run_o  (status)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected output level from the requirements (R3, R4, R5).
    function automatic bit exp_out(input bit p, input bit r, input bit m, input bit rc);
        return (m | (p & r)) ? rc : 1'b0;
    endfunction

    // Pulse-width monitor: every high phase must be H cycles (R7, R2).
    int  wid [N];
    int  rwid;
    logic [N-1:0] prev_o;
    logic prev_r;
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) wid[i] = 0;
            rwid = 0; prev_o = '0; prev_r = 1'b0;
        end else if (!done) begin
            for (int i = 0; i < N; i++) begin
                if (clk_out[i]) wid[i]++;
                else if (prev_o[i]) begin
                    check(wid[i] == H && prev_r && !ref_clk, "R7 pulse width", wid[i], H);
                    wid[i] = 0;
                end
            end
            if (ref_clk) rwid++;
            else if (prev_r) begin
                check(rwid == H, "R2 ref high width", rwid, H);
                rwid = 0;
            end
            prev_o = clk_out; prev_r = ref_clk;
        end
    end

    // Hold the current inputs, then compare outputs over two periods.
    task automatic window(input string req);
        bit [N-1:0] bad = '0;
        repeat (SETTLE) @(negedge clk);
        for (int c = 0; c < 2 * P; c++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++)
                if (clk_out[i] !== exp_out(pin_n, reg_n, mask[i], ref_clk)) bad[i] = 1'b1;
        end
        for (int i = 0; i < N; i++)
            check(!bad[i], mask[i] ? "R5 free-run output" : req, bad[i], 0);
        check(status === (pin_n & reg_n), "R8 status read-back", status, pin_n & reg_n);
    endtask

    initial begin
        int seen;
        void'($urandom(32'd4242));
        // R1: reset state
        repeat (5) @(negedge clk);
        check(clk_out === '0, "R1 outputs low in reset", clk_out, 0);
        check(ref_clk === 1'b0, "R1 ref low in reset", ref_clk, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(clk_out === {N{ref_clk}} && ref_clk === 1'b1, "R1 run in phase after reset", clk_out, {N{1'b1}});
        window("R1 running after reset");

        // R8: status latency of two cycles for a pin change
        pin_n = 1'b0;
        @(negedge clk);
        check(status === 1'b1, "R8 status before sync", status, 1);
        @(negedge clk);
        check(status === 1'b0, "R8 status after two cycles", status, 0);
        window("R3 pin stop");

        // R6: restart latency and common start edge
        pin_n = 1'b1;
        seen = 0;
        for (int c = 1; c <= 3 * P && seen == 0; c++) begin
            @(negedge clk);
            if (clk_out != '0) seen = c;
        end
        check(seen > 0 && seen <= 2 * P, "R6 restart within two periods", seen, 2 * P);
        check(clk_out === {N{1'b1}} && ref_clk === 1'b1, "R6 all resume together", clk_out, {N{1'b1}});

        // R4: register bit alone stops
        reg_n = 1'b0;
        window("R4 register stop");
        reg_n = 1'b1;
        window("R6 running after release");

        // R5: mixed mask with both sources low
        mask = 4'b1010; pin_n = 1'b0; reg_n = 1'b0;
        window("R3 stopped with mask");
        mask = '0; pin_n = 1'b1; reg_n = 1'b1;

        // Random stop windows
        for (int k = 0; k < 60; k++) begin
            pin_n = 1'($urandom_range(0, 1));
            reg_n = 1'($urandom_range(0, 3) != 0);
            mask  = N'($urandom);
            window(!pin_n ? "R3 random pin stop" : (!reg_n ? "R4 random reg stop" : "R6 random run"));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule